// File: doc/BRIEF.md
# Virtual Message Queue Translator

A network endpoint keeps a large space of virtual message queues (512 by default), but only a few of them (16 by default) are backed by hardware receive queues at any moment. This block sits on both message paths of the endpoint. Outgoing messages carry a virtual destination. The block looks that destination up in a per-queue table and sends the message on with a physical node identifier and the remote virtual receive queue number. Incoming messages carry a virtual receive queue number. The block matches it against the resident set and steers the message to the hardware queue that holds it. When there is no resident mapping, the message goes to a fixed service queue, where supervisory software emulates the queue.

Only the configuration port can change the mappings, so supervisory software can evict, swap or migrate queues without the application taking part. Both paths are valid/ready streams with one register stage each. A beat is taken on a clock edge where valid and ready are both high. An input is ready whenever its output register is empty or its output is being taken in the same cycle. A stalled output holds its beat unchanged. Configuration pins are plain and a write takes effect on the edge where `cfg_we` is high.

Top module: `vq_xlate`

## Requirements
- R1: After reset both output valids are low and every mapping is invalid, so a transmit lookup goes to the service path and a receive lookup yields the service queue.
- R2: A transmit beat whose virtual destination has a valid entry leaves with that entry's node and remote queue number, `tx_out_svc`=0, and its payload unchanged.
- R3: A transmit beat whose entry is invalid leaves with `tx_out_svc`=1 (error flag, service path), node 0, `tx_out_rvq` equal to its own virtual destination, and its payload unchanged.
- R4: A receive beat whose queue number matches a valid resident slot leaves with `rx_out_hit`=1 and `rx_out_hwq` equal to that slot's index (0 to 15).
- R5: A receive beat with no valid matching slot leaves with `rx_out_hit`=0 and `rx_out_hwq`=16, the service queue index.
- R6: When several valid slots hold the same queue number, the lowest slot index wins.
- R7: Each path has one cycle of latency. Its input is ready when its output is empty or is being taken. A stalled output beat stays unchanged.
- R8: A configuration write and a lookup of the same entry on the same edge give the old mapping. The new mapping applies to lookups on later edges.
- R9: With `cfg_tgt`=0 a write sets the transmit entry at `cfg_addr` to {`cfg_en`, `cfg_node`, `cfg_vq`}. With `cfg_tgt`=1 it sets resident slot `cfg_addr[3:0]` to {`cfg_en`, `cfg_vq`} and ignores the upper address bits. `cfg_en`=0 invalidates the entry.
- R10: The transmit and receive paths run on the same edge independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 1 | 0 = transmit table, 1 = resident slots |
| cfg_addr | input | 9 | Entry (transmit) or slot in low 4 bits (receive) |
| cfg_en | input | 1 | Valid bit written to the entry |
| cfg_node | input | 8 | Node identifier (transmit table only) |
| cfg_vq | input | 9 | Remote queue (transmit) or matched queue (receive) |
| tx_in_valid | input | 1 | Transmit beat offered |
| tx_in_ready | output | 1 | Transmit beat can be taken |
| tx_in_vdest | input | 9 | Virtual destination |
| tx_in_payload | input | 32 | Transmit payload |
| tx_out_valid | output | 1 | Translated transmit beat present |
| tx_out_ready | input | 1 | Downstream takes the transmit beat |
| tx_out_node | output | 8 | Physical destination node |
| tx_out_rvq | output | 9 | Remote virtual receive queue |
| tx_out_svc | output | 1 | Lookup failed, beat goes to service path |
| tx_out_payload | output | 32 | Transmit payload |
| rx_in_valid | input | 1 | Receive beat offered |
| rx_in_ready | output | 1 | Receive beat can be taken |
| rx_in_rvq | input | 9 | Virtual receive queue number |
| rx_in_payload | input | 32 | Receive payload |
| rx_out_valid | output | 1 | Steered receive beat present |
| rx_out_ready | input | 1 | Downstream takes the receive beat |
| rx_out_hwq | output | 5 | Hardware queue index, 16 = service queue |
| rx_out_hit | output | 1 | Resident mapping found |
| rx_out_payload | output | 32 | Receive payload |

## Verification
The block holds no hidden history apart from its tables and its two output registers. A corrupted table entry or slot therefore shows up on the first lookup that touches it, one cycle after that beat is taken, as a wrong node, queue number or service flag. A fault in an output register shows up in the same cycle as a mismatch of valid, ready or a stalled beat that changes. The bench keeps its own mappings and expected output registers and compares every port each cycle under random traffic, random back-pressure and random configuration writes. Directed sequences then cover same-edge write and lookup, duplicate slots and ignored address bits.

// File: rtl/vq_xlate_pkg.sv
package vq_xlate_pkg;
  typedef enum logic {
    CFG_TX_TBL = 1'b0,
    CFG_RX_CAM = 1'b1
  } cfg_tgt_e;
endpackage

// File: rtl/vq_pipe_reg.sv
module vq_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  // R7: a stalled beat must not move or change
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: a taken beat appears one cycle later
  assert_accept_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/vq_tx_map.sv
module vq_tx_map #(
  parameter int VQ_N   = 512,
  parameter int NODE_W = 8,
  parameter int PAY_W  = 32,
  localparam int VQ_W  = $clog2(VQ_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [VQ_W-1:0]   cfg_addr,
  input  logic              cfg_en,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic [VQ_W-1:0]   cfg_rvq,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VQ_W-1:0]   in_vdest,
  input  logic [PAY_W-1:0]  in_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NODE_W-1:0] out_node,
  output logic [VQ_W-1:0]   out_rvq,
  output logic              out_svc,
  output logic [PAY_W-1:0]  out_payload
);
  localparam int BEAT_W = 1 + NODE_W + VQ_W + PAY_W;

  logic [VQ_N-1:0]   ent_ok;
  logic [NODE_W-1:0] ent_node [VQ_N];
  logic [VQ_W-1:0]   ent_rvq  [VQ_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_ok <= '0;
    else if (cfg_we) ent_ok[cfg_addr] <= cfg_en;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      ent_node[cfg_addr] <= cfg_node;
      ent_rvq[cfg_addr]  <= cfg_rvq;
    end
  end

  logic              lk_hit;
  logic [NODE_W-1:0] lk_node;
  logic [VQ_W-1:0]   lk_rvq;

  always_comb begin
    lk_hit  = ent_ok[in_vdest];
    lk_node = lk_hit ? ent_node[in_vdest] : '0;
    lk_rvq  = lk_hit ? ent_rvq[in_vdest] : in_vdest;
  end

  logic [BEAT_W-1:0] beat_in, beat_out;
  assign beat_in = {!lk_hit, lk_node, lk_rvq, in_payload};

  vq_pipe_reg #(.W(BEAT_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(beat_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(beat_out)
  );

  assign {out_svc, out_node, out_rvq, out_payload} = beat_out;

  // R3: a service-path beat never names a physical node
  assert_tx_miss_node_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_svc) |-> (out_node == '0));
endmodule

// File: rtl/vq_rx_cam.sv
module vq_rx_cam #(
  parameter int HWQ_N = 16,
  parameter int VQ_W  = 9,
  parameter int PAY_W = 32,
  localparam int SLOT_W = $clog2(HWQ_N),
  localparam int HQ_W   = $clog2(HWQ_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              cfg_en,
  input  logic [VQ_W-1:0]   cfg_vq,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VQ_W-1:0]   in_rvq,
  input  logic [PAY_W-1:0]  in_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HQ_W-1:0]   out_hwq,
  output logic              out_hit,
  output logic [PAY_W-1:0]  out_payload
);
  localparam logic [HQ_W-1:0] SVC_Q = HQ_W'(HWQ_N);
  localparam int BEAT_W = 1 + HQ_W + PAY_W;

  logic [HWQ_N-1:0] slot_ok;
  logic [VQ_W-1:0]  slot_vq [HWQ_N];
  logic [HWQ_N-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_ok <= '0;
    else if (cfg_we) slot_ok[cfg_slot] <= cfg_en;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) slot_vq[cfg_slot] <= cfg_vq;
  end

  for (genvar g = 0; g < HWQ_N; g++) begin : g_cmp
    assign match[g] = slot_ok[g] && (slot_vq[g] == in_rvq);
  end

  logic [HQ_W-1:0] pick;
  always_comb begin
    pick = SVC_Q;
    for (int i = HWQ_N - 1; i >= 0; i--) begin
      if (match[i]) pick = HQ_W'(i);
    end
  end

  logic [BEAT_W-1:0] beat_in, beat_out;
  assign beat_in = {|match, pick, in_payload};

  vq_pipe_reg #(.W(BEAT_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(beat_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(beat_out)
  );

  assign {out_hit, out_hwq, out_payload} = beat_out;

  // R5: a miss is always steered to the service queue
  assert_rx_miss_svc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_hwq == SVC_Q));

  // R4: a hit always names a real resident queue
  assert_rx_hit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_hwq < SVC_Q));
endmodule

// File: rtl/vq_xlate.sv
module vq_xlate
  import vq_xlate_pkg::*;
#(
  parameter int VQ_N   = 512,
  parameter int HWQ_N  = 16,
  parameter int NODE_W = 8,
  parameter int PAY_W  = 32,
  localparam int VQ_W   = $clog2(VQ_N),
  localparam int SLOT_W = $clog2(HWQ_N),
  localparam int HQ_W   = $clog2(HWQ_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_tgt,
  input  logic [VQ_W-1:0]   cfg_addr,
  input  logic              cfg_en,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic [VQ_W-1:0]   cfg_vq,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [VQ_W-1:0]   tx_in_vdest,
  input  logic [PAY_W-1:0]  tx_in_payload,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [NODE_W-1:0] tx_out_node,
  output logic [VQ_W-1:0]   tx_out_rvq,
  output logic              tx_out_svc,
  output logic [PAY_W-1:0]  tx_out_payload,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [VQ_W-1:0]   rx_in_rvq,
  input  logic [PAY_W-1:0]  rx_in_payload,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [HQ_W-1:0]   rx_out_hwq,
  output logic              rx_out_hit,
  output logic [PAY_W-1:0]  rx_out_payload
);
  logic tx_we, rx_we;
  assign tx_we = cfg_we && (cfg_tgt == CFG_TX_TBL);
  assign rx_we = cfg_we && (cfg_tgt == CFG_RX_CAM);

  vq_tx_map #(.VQ_N(VQ_N), .NODE_W(NODE_W), .PAY_W(PAY_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(tx_we), .cfg_addr(cfg_addr), .cfg_en(cfg_en),
    .cfg_node(cfg_node), .cfg_rvq(cfg_vq),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready),
    .in_vdest(tx_in_vdest), .in_payload(tx_in_payload),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready),
    .out_node(tx_out_node), .out_rvq(tx_out_rvq),
    .out_svc(tx_out_svc), .out_payload(tx_out_payload)
  );

  vq_rx_cam #(.HWQ_N(HWQ_N), .VQ_W(VQ_W), .PAY_W(PAY_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(rx_we), .cfg_slot(cfg_addr[SLOT_W-1:0]), .cfg_en(cfg_en),
    .cfg_vq(cfg_vq),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready),
    .in_rvq(rx_in_rvq), .in_payload(rx_in_payload),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .out_hwq(rx_out_hwq), .out_hit(rx_out_hit),
    .out_payload(rx_out_payload)
  );

  // R1: nothing leaves during reset release
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_out_valid && !rx_out_valid));
endmodule

// File: tb/vq_xlate_tb_top.sv
module vq_xlate_tb_top;
  localparam int VQ_N = 512, HWQ_N = 16, NODE_W = 8, PAY_W = 32;
  localparam int VQ_W = 9, HQ_W = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_tgt = 0, cfg_en = 0;
  logic [VQ_W-1:0] cfg_addr = 0, cfg_vq = 0;
  logic [NODE_W-1:0] cfg_node = 0;
  logic tx_in_valid = 0, tx_out_ready = 1, rx_in_valid = 0, rx_out_ready = 1;
  logic [VQ_W-1:0] tx_in_vdest = 0, rx_in_rvq = 0;
  logic [PAY_W-1:0] tx_in_payload = 0, rx_in_payload = 0;
  logic tx_in_ready, tx_out_valid, tx_out_svc, rx_in_ready, rx_out_valid, rx_out_hit;
  logic [NODE_W-1:0] tx_out_node;
  logic [VQ_W-1:0] tx_out_rvq;
  logic [PAY_W-1:0] tx_out_payload, rx_out_payload;
  logic [HQ_W-1:0] rx_out_hwq;

  always #4 clk = ~clk;

  vq_xlate dut_i (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  bit m_tx_ok [VQ_N]; int m_tx_node [VQ_N]; int m_tx_rvq [VQ_N];
  bit m_rx_ok [HWQ_N]; int m_rx_vq [HWQ_N];
  bit e_tx_v, e_tx_svc, e_rx_v, e_rx_hit;
  int e_tx_node, e_tx_rvq, e_rx_hwq;
  longint e_tx_pay, e_rx_pay;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_tx_v = 0; e_rx_v = 0;
      for (int i = 0; i < VQ_N; i++) m_tx_ok[i] = 0;
      for (int i = 0; i < HWQ_N; i++) m_rx_ok[i] = 0;
    end else begin
      if (tx_in_valid && (!e_tx_v || tx_out_ready)) begin
        e_tx_v = 1; e_tx_pay = tx_in_payload;
        if (m_tx_ok[tx_in_vdest]) begin
          e_tx_svc = 0; e_tx_node = m_tx_node[tx_in_vdest]; e_tx_rvq = m_tx_rvq[tx_in_vdest];
        end else begin
          e_tx_svc = 1; e_tx_node = 0; e_tx_rvq = tx_in_vdest;
        end
      end else if (tx_out_ready) e_tx_v = 0;
      if (rx_in_valid && (!e_rx_v || rx_out_ready)) begin
        e_rx_v = 1; e_rx_pay = rx_in_payload; e_rx_hwq = HWQ_N;
        for (int i = HWQ_N - 1; i >= 0; i--)
          if (m_rx_ok[i] && m_rx_vq[i] == int'(rx_in_rvq)) e_rx_hwq = i;
        e_rx_hit = (e_rx_hwq != HWQ_N);
      end else if (rx_out_ready) e_rx_v = 0;
      if (cfg_we) begin
        if (cfg_tgt == 0) begin
          m_tx_ok[cfg_addr] = cfg_en; m_tx_node[cfg_addr] = cfg_node; m_tx_rvq[cfg_addr] = cfg_vq;
        end else begin
          m_rx_ok[cfg_addr % HWQ_N] = cfg_en; m_rx_vq[cfg_addr % HWQ_N] = cfg_vq;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 tx_out_valid", tx_out_valid, e_tx_v);
      chk("R7 tx_in_ready", tx_in_ready, !e_tx_v || tx_out_ready);
      chk("R7 rx_out_valid", rx_out_valid, e_rx_v);
      chk("R7 rx_in_ready", rx_in_ready, !e_rx_v || rx_out_ready);
      if (e_tx_v) begin
        chk(e_tx_svc ? "R3 tx_out_svc" : "R2 tx_out_svc", tx_out_svc, e_tx_svc);
        chk(e_tx_svc ? "R3 tx_out_node" : "R2 tx_out_node", tx_out_node, e_tx_node);
        chk(e_tx_svc ? "R3 tx_out_rvq" : "R2 tx_out_rvq", tx_out_rvq, e_tx_rvq);
        chk("R2 tx_out_payload", tx_out_payload, e_tx_pay);
      end
      if (e_rx_v) begin
        chk(e_rx_hit ? "R4 rx_out_hit" : "R5 rx_out_hit", rx_out_hit, e_rx_hit);
        chk(e_rx_hit ? "R4 rx_out_hwq" : "R5 rx_out_hwq", rx_out_hwq, e_rx_hwq);
        chk("R4 rx_out_payload", rx_out_payload, e_rx_pay);
      end
    end
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic clr(); tx_in_valid = 0; rx_in_valid = 0; cfg_we = 0; endtask
  task automatic put_tx(int v, int p);
    tx_in_valid = 1; tx_in_vdest = VQ_W'(v); tx_in_payload = PAY_W'(p);
  endtask
  task automatic put_rx(int q, int p);
    rx_in_valid = 1; rx_in_rvq = VQ_W'(q); rx_in_payload = PAY_W'(p);
  endtask
  task automatic put_cfg(int tgt, int a, int en, int node, int vq);
    cfg_we = 1; cfg_tgt = tgt[0]; cfg_addr = VQ_W'(a); cfg_en = en[0];
    cfg_node = NODE_W'(node); cfg_vq = VQ_W'(vq);
  endtask
  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step(); @(negedge clk);
    chk("R1 tx_out_valid after reset", tx_out_valid, 0);
    chk("R1 rx_out_valid after reset", rx_out_valid, 0);
    // R1: fresh tables miss
    step(); put_tx(5, 11); put_rx(7, 12); step(); clr(); @(negedge clk);
    chk("R1 tx svc after reset", tx_out_svc, 1);
    chk("R1 rx hwq after reset", rx_out_hwq, 16);
    // R9 / R2: program and use
    step(); put_cfg(0, 5, 1, 3, 100); step(); clr(); put_tx(5, 21); step(); clr(); @(negedge clk);
    chk("R2 node", tx_out_node, 3);
    chk("R2 rvq", tx_out_rvq, 100);
    chk("R9 svc after write", tx_out_svc, 0);
    // R3: unmapped
    step(); put_tx(6, 22); step(); clr(); @(negedge clk);
    chk("R3 svc", tx_out_svc, 1);
    chk("R3 rvq carries vdest", tx_out_rvq, 6);
    // R8: same-edge write and lookup
    step(); put_cfg(0, 5, 1, 9, 200); put_tx(5, 23); step(); clr(); @(negedge clk);
    chk("R8 old node", tx_out_node, 3);
    step(); put_tx(5, 24); step(); clr(); @(negedge clk);
    chk("R8 new node", tx_out_node, 9);
    chk("R8 new rvq", tx_out_rvq, 200);
    // R9: invalidate
    step(); put_cfg(0, 5, 0, 9, 200); step(); clr(); put_tx(5, 25); step(); clr(); @(negedge clk);
    chk("R9 invalidated", tx_out_svc, 1);
    // R6 / R4: resident slots
    step(); put_cfg(1, 9, 1, 0, 40); step(); put_cfg(1, 2, 1, 0, 40);
    step(); put_cfg(1, 4, 1, 0, 41); step(); clr();
    put_rx(40, 31); step(); clr(); @(negedge clk);
    chk("R6 lowest slot", rx_out_hwq, 2);
    step(); put_rx(41, 32); step(); clr(); @(negedge clk);
    chk("R4 hwq", rx_out_hwq, 4);
    chk("R4 hit", rx_out_hit, 1);
    step(); put_cfg(1, 2, 0, 0, 40); step(); clr(); put_rx(40, 33); step(); clr(); @(negedge clk);
    chk("R6 next slot", rx_out_hwq, 9);
    // R9: upper address bits ignored for slots
    step(); put_cfg(1, 19, 1, 0, 50); step(); clr(); put_rx(50, 34); step(); clr(); @(negedge clk);
    chk("R9 slot from low bits", rx_out_hwq, 3);
    // R5: miss
    step(); put_rx(77, 35); step(); clr(); @(negedge clk);
    chk("R5 svc queue", rx_out_hwq, 16);
    chk("R5 hit low", rx_out_hit, 0);
    // R10: both paths together
    step(); put_cfg(0, 8, 1, 44, 300); step(); clr(); put_tx(8, 41); put_rx(41, 42); step(); clr(); @(negedge clk);
    chk("R10 tx node", tx_out_node, 44);
    chk("R10 rx hwq", rx_out_hwq, 4);
    // R7: stall holds
    step(); tx_out_ready = 0; put_tx(8, 51); step(); put_tx(6, 52); step(); @(negedge clk);
    chk("R7 in_ready low when stalled", tx_in_ready, 0);
    chk("R7 held payload", tx_out_payload, 51);
    step(); tx_out_ready = 1; step(); clr(); @(negedge clk);
    chk("R7 second beat", tx_out_payload, 52);
    // random traffic with back-pressure and reconfiguration
    for (int c = 0; c < 4000; c++) begin
      step();
      tx_out_ready = ($urandom % 4) != 0;
      rx_out_ready = ($urandom % 4) != 0;
      tx_in_valid = $urandom % 2;
      tx_in_vdest = ($urandom % 2) ? VQ_W'($urandom % 8) : VQ_W'($urandom);
      tx_in_payload = $urandom;
      rx_in_valid = $urandom % 2;
      rx_in_rvq = VQ_W'($urandom % 12);
      rx_in_payload = $urandom;
      if ($urandom % 6 == 0)
        put_cfg($urandom % 2, ($urandom % 2) ? ($urandom % 8) : ($urandom % 512),
                ($urandom % 4) != 0, $urandom % 256, $urandom % 12);
      else cfg_we = 0;
    end
    step(); clr(); tx_out_ready = 1; rx_out_ready = 1;
    repeat (3) step();
    finish_run();
  end
endmodule